// File: doc/BRIEF.md
# Clock Generator Serial Control Register File

This block is the serial control front end of a programmable clock generator. It is an I2C target on a two-wire bus. A system clock that runs much faster than the bus samples SCL and SDA, so the same logic serves standard-mode (100 kHz) and fast-mode (400 kHz) masters. One strap input picks one of two bus addresses. This allows two generators to share a bus.

A write transfer starts with a pointer byte that selects one of twelve registers. Each data byte after it goes to the selected register, and the pointer then advances by one, wrapping from 11 back to 0. A read transfer returns bytes from the current pointer in the same way. Register 0 is a write-only command register. It fires self-clearing resets for the PLL and the phase adjuster, and it commits the staged control values. Registers 1 to 8 are read/write staging (shadow) registers. Their values reach the control outputs only on a commit, so a multi-byte update lands on the PLL and the phase adjuster in a single system cycle. Registers 9 to 11 are read-only and report the lock flags and other status inputs.

Top module: `clkgen_i2c_regs`

## Requirements
- R1: With `addr_sel_i` low, the block acknowledges the 7-bit address 26h (write byte 4Ch, read byte 4Dh). For any other address it leaves SDA released and ignores the transfer until the next START.
- R2: With `addr_sel_i` high, the block acknowledges the 7-bit address 27h (write byte 4Eh, read byte 4Fh), and 26h is not acknowledged.
- R3: In a write transfer, the first byte after the address loads the register pointer. A value of 12 or more loads 0. The pointer advances by one after every data byte written or read and wraps from 11 to 0. A repeated START keeps the pointer.
- R4: Register 0 is write-only and reads as 00h. Its bit 0 requests a PLL reset, bit 1 requests a phase-adjuster reset, and bit 2 requests a commit.
- R5: Registers 1 to 8 are read/write. A write updates the staging value, and a read returns the staging value.
- R6: `ctrl_o` carries the committed copy of registers 1 to 8. Register k occupies bits [8k-1 : 8k-8]. All eight bytes take the staging values together when register 0 is written with bit 2 set. At no other time does `ctrl_o` change.
- R7: Each write to register 0 with bit 0 (bit 1) set produces exactly one system-cycle-wide high pulse on `pll_rst_o` (`phase_rst_o`). The two resets are independent.
- R8: Register 9 reads {6'b0, `phase_lock_i`, `pll_lock_i`}. Register 10 reads `aux_status_i[7:0]` and register 11 reads `aux_status_i[15:8]`. Writes to registers 9 to 11 are acknowledged and change nothing.
- R9: In a read, the data is driven MSB first, with SDA changing only after SCL falls. The block sends the next byte after a master ACK and releases SDA after a master NACK.
- R10: Transfers work at both bus rates: a 250-cycle bit (400 kHz) and a 1000-cycle bit (100 kHz) of the system clock.
- R11: After reset, SDA is released, `ctrl_o` and all staging registers are 0, and neither reset pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 1 | Bus address select strap |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| pll_lock_i | input | 1 | PLL lock flag for status |
| phase_lock_i | input | 1 | Phase adjuster lock flag for status |
| aux_status_i | input | 16 | Extra status bytes for registers 10 and 11 |
| ctrl_o | output | 64 | Committed control bytes of registers 1 to 8 |
| pll_rst_o | output | 1 | One-cycle PLL software reset pulse |
| phase_rst_o | output | 1 | One-cycle phase adjuster software reset pulse |

## Verification
Every line change passes through a two-stage synchronizer and an edge register. The block therefore responds about four system cycles after an SCL edge: it drives ACK or data bits after a fall, and it samples after a rise. The bench drives data a quarter bit after each SCL fall and samples SDA a quarter bit after each rise, well clear of that latency. Register writes reach the command logic two cycles after the SCL fall that ends a byte. The bench reads `ctrl_o` only after the STOP, tens of cycles later. It counts the reset pulses with an edge-and-level monitor over the whole transfer, so the exact cycle of each pulse does not matter.

// File: rtl/clkgen_i2c_pkg.sv
package clkgen_i2c_pkg;

    localparam int BYTE_W = 8;

    // command register bit positions
    localparam int CMD_PLL_RST_BIT = 0;
    localparam int CMD_PH_RST_BIT  = 1;
    localparam int CMD_COMMIT_BIT  = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_DATA,
        PH_WR_ACK,
        PH_RD_DATA,
        PH_RD_ACK
    } bus_phase_e;

endpackage

// File: rtl/cg_line_sync.sv
module cg_line_sync #(
    parameter int NLINES = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] raw_i,
    output logic [NLINES-1:0] level_o,
    output logic [NLINES-1:0] prev_o
);
    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [CHAIN_W-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN_W-2:0], raw_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign prev_o[g]  = chain_q[STAGES];
    end

endmodule

// File: rtl/cg_i2c_engine.sv
module cg_i2c_engine
    import clkgen_i2c_pkg::*;
#(
    parameter int         NREG      = 12,
    parameter int         IDXW      = 4,
    parameter logic [6:0] ADDR_BASE = 7'h26
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_sel_i,
    input  logic                scl_lvl_i,
    input  logic                scl_prv_i,
    input  logic                sda_lvl_i,
    input  logic                sda_prv_i,
    output logic                sda_oe_o,
    output logic [IDXW-1:0]     rd_idx_o,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic                wr_o,
    output logic [IDXW-1:0]     wr_idx_o,
    output logic [BYTE_W-1:0]   wr_data_o
);
    localparam logic [IDXW-1:0]   LAST_IDX = IDXW'(NREG - 1);
    localparam logic [BYTE_W-1:0] NREG_B   = BYTE_W'(NREG);

    typedef struct packed {
        bus_phase_e          st;
        logic [3:0]          bits;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic                first;
        logic                mack;
        logic                drv;
        logic [IDXW-1:0]     ptr;
        logic                wr;
        logic [IDXW-1:0]     widx;
        logic [BYTE_W-1:0]   wdat;
    } eng_t;

    eng_t r_q, r_d;

    logic scl_rise, scl_fall, start_c, stop_c;
    logic [6:0] my_addr;

    assign scl_rise = scl_lvl_i & ~scl_prv_i;
    assign scl_fall = ~scl_lvl_i & scl_prv_i;
    assign start_c  = scl_lvl_i & scl_prv_i & sda_prv_i & ~sda_lvl_i;
    assign stop_c   = scl_lvl_i & scl_prv_i & ~sda_prv_i & sda_lvl_i;
    assign my_addr  = ADDR_BASE + {6'b0, addr_sel_i};

    function automatic logic [IDXW-1:0] ptr_next(input logic [IDXW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d    = r_q;
        r_d.wr = 1'b0;
        if (stop_c) begin
            r_d.st  = PH_IDLE;
            r_d.drv = 1'b0;
        end else if (start_c) begin
            r_d.st   = PH_ADDR;
            r_d.bits = '0;
            r_d.drv  = 1'b0;
        end else begin
            unique case (r_q.st)
                PH_IDLE: ;
                PH_ADDR: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_lvl_i};
                        r_d.bits = r_q.bits + 1'b1;
                    end else if (scl_fall && r_q.bits == 4'd8) begin
                        if (r_q.sh[7:1] == my_addr) begin
                            r_d.st  = PH_ADDR_ACK;
                            r_d.rw  = r_q.sh[0];
                            r_d.drv = 1'b1;
                        end else begin
                            r_d.st  = PH_IDLE;
                            r_d.drv = 1'b0;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall) begin
                        r_d.bits = '0;
                        if (r_q.rw) begin
                            r_d.st  = PH_RD_DATA;
                            r_d.sh  = rd_data_i;
                            r_d.drv = ~rd_data_i[BYTE_W-1];
                            r_d.ptr = ptr_next(r_q.ptr);
                        end else begin
                            r_d.st    = PH_WR_DATA;
                            r_d.drv   = 1'b0;
                            r_d.first = 1'b1;
                        end
                    end
                end
                PH_WR_DATA: begin
                    if (scl_rise) begin
                        r_d.sh   = {r_q.sh[BYTE_W-2:0], sda_lvl_i};
                        r_d.bits = r_q.bits + 1'b1;
                    end else if (scl_fall && r_q.bits == 4'd8) begin
                        if (r_q.first) begin
                            r_d.first = 1'b0;
                            r_d.ptr   = (r_q.sh < NREG_B) ? r_q.sh[IDXW-1:0] : '0;
                        end else begin
                            r_d.wr   = 1'b1;
                            r_d.widx = r_q.ptr;
                            r_d.wdat = r_q.sh;
                            r_d.ptr  = ptr_next(r_q.ptr);
                        end
                        r_d.drv = 1'b1;
                        r_d.st  = PH_WR_ACK;
                    end
                end
                PH_WR_ACK: begin
                    if (scl_fall) begin
                        r_d.drv  = 1'b0;
                        r_d.bits = '0;
                        r_d.st   = PH_WR_DATA;
                    end
                end
                PH_RD_DATA: begin
                    if (scl_fall) begin
                        if (r_q.bits == 4'd7) begin
                            r_d.drv = 1'b0;
                            r_d.st  = PH_RD_ACK;
                        end else begin
                            r_d.bits = r_q.bits + 1'b1;
                            r_d.sh   = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.drv  = ~r_q.sh[BYTE_W-2];
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl_i;
                    end else if (scl_fall) begin
                        r_d.bits = '0;
                        if (r_q.mack) begin
                            r_d.st  = PH_RD_DATA;
                            r_d.sh  = rd_data_i;
                            r_d.drv = ~rd_data_i[BYTE_W-1];
                            r_d.ptr = ptr_next(r_q.ptr);
                        end else begin
                            r_d.st  = PH_IDLE;
                            r_d.drv = 1'b0;
                        end
                    end
                end
                default: begin
                    r_d.st  = PH_IDLE;
                    r_d.drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PH_IDLE, bits: '0, sh: '0, rw: 1'b0, first: 1'b0,
                     mack: 1'b0, drv: 1'b0, ptr: '0, wr: 1'b0, widx: '0, wdat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o  = r_q.drv;
    assign rd_idx_o  = r_q.ptr;
    assign wr_o      = r_q.wr;
    assign wr_idx_o  = r_q.widx;
    assign wr_data_o = r_q.wdat;

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ptr <= LAST_IDX); // R3
    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.drv) |-> $past(scl_fall)); // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PH_IDLE) |-> !r_q.drv); // R1
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !r_q.drv); // R9

endmodule

// File: rtl/cg_ctrl_bank.sv
module cg_ctrl_bank
    import clkgen_i2c_pkg::*;
#(
    parameter int NUM_RW = 8,
    parameter int NUM_RO = 3,
    parameter int IDXW   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [IDXW-1:0]              wr_idx_i,
    input  logic [BYTE_W-1:0]            wr_data_i,
    input  logic [IDXW-1:0]              rd_idx_i,
    output logic [BYTE_W-1:0]            rd_data_o,
    input  logic                         pll_lock_i,
    input  logic                         phase_lock_i,
    input  logic [(NUM_RO-1)*BYTE_W-1:0] aux_status_i,
    output logic [NUM_RW*BYTE_W-1:0]     ctrl_o,
    output logic                         pll_rst_o,
    output logic                         phase_rst_o
);
    localparam int RWW  = NUM_RW * BYTE_W;
    localparam int ROW  = NUM_RO * BYTE_W;
    localparam int NREG = 1 + NUM_RW + NUM_RO;

    typedef struct packed {
        logic [RWW-1:0] shadow;
        logic [RWW-1:0] active;
        logic           pll_rst;
        logic           ph_rst;
    } bank_t;

    bank_t r_q, r_d;
    logic [ROW-1:0] ro_bytes;

    assign ro_bytes = {aux_status_i, 6'b0, phase_lock_i, pll_lock_i};

    always_comb begin
        r_d         = r_q;
        r_d.pll_rst = 1'b0;
        r_d.ph_rst  = 1'b0;
        if (wr_i) begin
            if (wr_idx_i == '0) begin
                r_d.pll_rst = wr_data_i[CMD_PLL_RST_BIT];
                r_d.ph_rst  = wr_data_i[CMD_PH_RST_BIT];
                if (wr_data_i[CMD_COMMIT_BIT]) r_d.active = r_q.shadow;
            end else begin
                for (int i = 0; i < NUM_RW; i++) begin
                    if (wr_idx_i == IDXW'(i + 1)) r_d.shadow[i*BYTE_W +: BYTE_W] = wr_data_i;
                end
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_idx_i == IDXW'(i + 1)) rd_data_o = r_q.shadow[i*BYTE_W +: BYTE_W];
        end
        for (int i = 0; i < NUM_RO; i++) begin
            if (rd_idx_i == IDXW'(1 + NUM_RW + i)) rd_data_o = ro_bytes[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o      = r_q.active;
    assign pll_rst_o   = r_q.pll_rst;
    assign phase_rst_o = r_q.ph_rst;

    AST_PLL_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pll_rst |=> !r_q.pll_rst); // R7
    AST_PH_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ph_rst |=> !r_q.ph_rst); // R7
    AST_ACTIVE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && wr_idx_i == '0 && wr_data_i[CMD_COMMIT_BIT]) |=> $stable(r_q.active)); // R6
    AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (wr_idx_i < IDXW'(NREG))); // R3

endmodule

// File: rtl/clkgen_i2c_regs.sv
module clkgen_i2c_regs
    import clkgen_i2c_pkg::*;
#(
    parameter int         NUM_RW      = 8,
    parameter int         NUM_RO      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_BASE   = 7'h26
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         addr_sel_i,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe_o,
    input  logic                         pll_lock_i,
    input  logic                         phase_lock_i,
    input  logic [(NUM_RO-1)*BYTE_W-1:0] aux_status_i,
    output logic [NUM_RW*BYTE_W-1:0]     ctrl_o,
    output logic                         pll_rst_o,
    output logic                         phase_rst_o
);
    localparam int NREG = 1 + NUM_RW + NUM_RO;
    localparam int IDXW = $clog2(NREG);

    logic [1:0]        lvl, prv;
    logic [IDXW-1:0]   rd_idx, wr_idx;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic              wr;

    cg_line_sync #(.NLINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({scl_i, sda_i}),
        .level_o (lvl),
        .prev_o  (prv)
    );

    cg_i2c_engine #(.NREG(NREG), .IDXW(IDXW), .ADDR_BASE(ADDR_BASE)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel_i (addr_sel_i),
        .scl_lvl_i  (lvl[1]),
        .scl_prv_i  (prv[1]),
        .sda_lvl_i  (lvl[0]),
        .sda_prv_i  (prv[0]),
        .sda_oe_o   (sda_oe_o),
        .rd_idx_o   (rd_idx),
        .rd_data_i  (rd_data),
        .wr_o       (wr),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    cg_ctrl_bank #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .IDXW(IDXW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .rd_idx_i     (rd_idx),
        .rd_data_o    (rd_data),
        .pll_lock_i   (pll_lock_i),
        .phase_lock_i (phase_lock_i),
        .aux_status_i (aux_status_i),
        .ctrl_o       (ctrl_o),
        .pll_rst_o    (pll_rst_o),
        .phase_rst_o  (phase_rst_o)
    );

endmodule

// File: tb/clkgen_i2c_regs_tb.sv
module clkgen_i2c_regs_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic sda_line, sda_oe;
    logic pll_lock = 1'b1, phase_lock = 1'b0;
    logic [15:0] aux = 16'hBEEF;
    logic [63:0] ctrl;
    logic pll_rst, phase_rst;

    int checks = 0, failures = 0, q = 62;
    bit done = 0;
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];
    logic rel_after_nack;

    int pll_hi = 0, pll_rise = 0, ph_hi = 0, ph_rise = 0;
    logic pll_prev = 0, ph_prev = 0;

    // ptr, write data, expected readback
    localparam logic [23:0] VEC [3] = '{24'h01_A5_A5, 24'h08_81_81, 24'h0A_FF_EF};

    always #5 clk = ~clk;
    assign sda_line = ~(m_sda_low | sda_oe);

    clkgen_i2c_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .pll_lock_i(pll_lock), .phase_lock_i(phase_lock),
        .aux_status_i(aux), .ctrl_o(ctrl), .pll_rst_o(pll_rst), .phase_rst_o(phase_rst)
    );

    always @(posedge clk) begin
        if (pll_rst) pll_hi++;
        if (pll_rst && !pll_prev) pll_rise++;
        if (phase_rst) ph_hi++;
        if (phase_rst && !ph_prev) ph_rise++;
        pll_prev <= pll_rst;
        ph_prev  <= phase_rst;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 0; m_scl = 1; tick(q);
        m_sda_low = 1; tick(q);
        m_scl = 0; tick(q);
    endtask

    task automatic bus_rstart();
        m_sda_low = 0; tick(q);
        m_scl = 1; tick(q);
        m_sda_low = 1; tick(q);
        m_scl = 0; tick(q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1; tick(q);
        m_scl = 1; tick(q);
        m_sda_low = 0; tick(q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; tick(q);
            m_scl = 1; tick(2 * q);
            m_scl = 0; tick(q);
        end
        m_sda_low = 0; tick(q);
        m_scl = 1; tick(q);
        ack = ~sda_line; tick(q);
        m_scl = 0; tick(q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = 0; tick(q);
            m_scl = 1; tick(q);
            b[i] = sda_line; tick(q);
            m_scl = 0; tick(q);
        end
        m_sda_low = ~nack; tick(q);
        m_scl = 1; tick(2 * q);
        m_scl = 0; tick(q);
        m_sda_low = 0;
    endtask

    task automatic write_burst(input logic [7:0] addr, input logic [7:0] ptr, input int n,
                               output logic all_ack);
        logic a;
        bus_start();
        send_byte(addr, a); all_ack = a;
        send_byte(ptr, a);  all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic write1(input logic [7:0] addr, input logic [7:0] ptr, input logic [7:0] v,
                          output logic ok);
        wbuf[0] = v;
        write_burst(addr, ptr, 1, ok);
    endtask

    task automatic read_burst(input logic [7:0] addr, input logic [7:0] ptr, input int n,
                              output logic all_ack);
        logic a;
        bus_start();
        send_byte(addr, a); all_ack = a;
        send_byte(ptr, a);  all_ack &= a;
        bus_rstart();
        send_byte(addr | 8'h01, a); all_ack &= a;
        for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
        tick(8);
        rel_after_nack = ~sda_oe;
        bus_stop();
    endtask

    task automatic probe(input logic [7:0] addr, output logic ack);
        bus_start();
        send_byte(addr, ack);
        bus_stop();
    endtask

    initial begin
        logic ok;
        tick(5);
        // R11: reset state
        chk("R11 sda released in reset", sda_oe, 0);
        chk("R11 ctrl_o in reset", ctrl, 0);
        chk("R11 pulses in reset", {pll_rst, phase_rst}, 0);
        rst_n = 1; tick(5);

        // R10: standard-mode write (1000-cycle bit) of reg3
        q = 250;
        write1(8'h4C, 8'h03, 8'h99, ok);
        chk("R10 standard-mode write ack", ok, 1);
        q = 62;

        // R1 R5 R8: table walk of single-byte writes
        foreach (VEC[k]) begin
            write1(8'h4C, VEC[k][23:16], VEC[k][15:8], ok);
            chk("R1 R8 write ack (table)", ok, 1);
        end

        // R2: high strap address pair
        addr_sel = 1;
        probe(8'h4C, ok);
        chk("R2 low-strap address ignored when strap high", ok, 0);
        write1(8'h4E, 8'h02, 8'h77, ok);
        chk("R2 write at 4Eh ack", ok, 1);
        read_burst(8'h4E, 8'h02, 1, ok);
        chk("R2 read at 4Fh ack", ok, 1);
        chk("R2 readback reg2", rbuf[0], 8'h77);
        addr_sel = 0;

        // R1: foreign address not acknowledged
        probe(8'h4E, ok);
        chk("R1 foreign address NACK", ok, 0);
        chk("R6 ctrl_o unchanged before commit", ctrl, 0);

        // R3 R4 R5 R8 R9: burst read of the whole map
        read_burst(8'h4C, 8'h00, 12, ok);
        chk("R9 burst read acks", ok, 1);
        chk("R9 SDA released after NACK", rel_after_nack, 1);
        chk("R4 write-only reg0 reads 00", rbuf[0], 8'h00);
        chk("R5 reg2 readback", rbuf[2], 8'h77);
        chk("R10 reg3 written at standard mode", rbuf[3], 8'h99);
        for (int i = 4; i < 8; i++) chk("R5 untouched reg reads 0", rbuf[i], 8'h00);
        chk("R8 lock status reg9", rbuf[9], 8'h01);
        chk("R8 aux high reg11", rbuf[11], 8'hBE);
        foreach (VEC[k]) chk("R3 R5 R8 table readback", rbuf[VEC[k][19:16]], VEC[k][7:0]);

        // R6: commit
        write1(8'h4C, 8'h00, 8'h04, ok);
        chk("R6 ctrl_o after commit", ctrl, 64'h8100_0000_0099_77A5);
        chk("R7 commit alone fires no reset", pll_rise + ph_rise, 0);

        // R3: pointer 200 loads 0, then auto-increment to reg1; no commit
        wbuf[0] = 8'h00; wbuf[1] = 8'h66;
        write_burst(8'h4C, 8'd200, 2, ok);
        chk("R3 out-of-range pointer write ack", ok, 1);
        chk("R6 staging write leaves ctrl_o", ctrl, 64'h8100_0000_0099_77A5);

        // R7: independent reset pulses
        write1(8'h4C, 8'h00, 8'h01, ok);
        chk("R7 pll pulse count", pll_rise, 1);
        chk("R7 pll pulse width", pll_hi, 1);
        chk("R7 phase idle on pll reset", ph_rise, 0);
        write1(8'h4C, 8'h00, 8'h02, ok);
        chk("R7 phase pulse count", ph_rise, 1);
        chk("R7 phase pulse width", ph_hi, 1);
        chk("R7 pll unchanged on phase reset", pll_rise, 1);

        // R3: read wraps 11 -> 0 -> 1
        read_burst(8'h4C, 8'd11, 3, ok);
        chk("R3 wrap read reg11", rbuf[0], 8'hBE);
        chk("R3 wrap read reg0", rbuf[1], 8'h00);
        chk("R3 wrap read reg1 via pointer 200", rbuf[2], 8'h66);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (198000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule